// File: doc/BRIEF.md
# Switchable Domain Power Sequencer

This block brings one gated logic domain up or down through a fixed, handshaked series of steps. It owns a five-bit control word for the domain's power switches, isolation, reset and clock gate. It also drives a four-bit SRAM power-down field and a bus-protection request mask. The acknowledge inputs from the switch fabric, the SRAM macros and the interconnect gate its progress. Per-domain parameters choose which SRAM acknowledge bits and which bus-protection bits take part. A zero mask removes the matching wait, or, for bus protection, the whole step.

A power request enters on a valid/ready pair: `req_on` gives the target state (1 = up, 0 = down). The request is taken on the cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle, so a requester must hold `req_valid` and `req_on` steady until it sees ready. `busy`, `done` and `err` are plain status pins. Every wait is bounded by a cycle-count timeout. A timeout freezes the outputs where they stand and raises `err`.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain is held off. `pwr_ctl` = 5'b10010, where bit 0 is active-low reset, bit 1 is isolation, bit 2 is the first switch stage, bit 3 is the second switch stage and bit 4 is clock disable. `sram_pdn` = 4'hF, `bus_prot_req` = BUS_MASK, `busy`/`done`/`err` are low and `req_ready` is high.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low for the whole time `busy` is high.
- R3: Power-up changes outputs in this order. Set bit 2, then set bit 3, then wait for both switch acknowledges to be 1. Clear bit 4, clear bit 1, set bit 0, then clear `sram_pdn`, then wait for the SRAM acknowledge. Finally drop `bus_prot_req` and wait for the bus-protection status.
- R4: Power-down changes outputs in this order. Raise `bus_prot_req` to BUS_MASK and wait. Set `sram_pdn` to 4'hF and wait. Set bit 1, clear bit 0, set bit 4, clear bit 2, clear bit 3.
- R5: Power-up does not go past the switch wait until `pwr_ack_a` and `pwr_ack_b` are both 1. Power-down completes only once both are 0.
- R6: The SRAM wait needs every SRAM_ACK_MASK bit of `sram_ack` to be 0 on power-up and 1 on power-down. With a zero mask the wait is skipped.
- R7: The bus-protection wait needs every BUS_MASK bit of `bus_prot_sta` to be 0 on power-up and 1 on power-down. With a zero mask the request field never changes and the step is skipped.
- R8: At most one output group changes per clock cycle. Each `pwr_ctl` bit is its own group, and `sram_pdn` and `bus_prot_req` are one group each.
- R9: The timeout counter reloads when a wait is entered. If a wait condition stays false for TIMEOUT cycles, `err` rises TIMEOUT cycles after the last output change. `busy` then drops and the outputs stay where they stopped, with no rollback.
- R10: A request for the state the domain is already in (known after reset or after a successful sequence) pulses `done` with no output change. After an error no state is known, so every request runs the full sequence.
- R11: `done` is a one-cycle pulse on success only. `err` holds until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Power request valid |
| req_on | input | 1 | Target state, 1 = up, 0 = down |
| req_ready | output | 1 | High while idle; request accepted when valid and ready |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Timeout error, held until next accepted request |
| pwr_ctl | output | 5 | Control word: [0] reset_n, [1] iso, [2] switch 1, [3] switch 2, [4] clock disable |
| sram_pdn | output | 4 | SRAM power-down lines |
| bus_prot_req | output | BUS_W | Bus-protection request bits |
| pwr_ack_a | input | 1 | First switch stage status |
| pwr_ack_b | input | 1 | Second switch stage status |
| sram_ack | input | SRAM_ACK_W | SRAM power-down acknowledges |
| bus_prot_sta | input | BUS_W | Bus-protection status |

## Verification
Each up or down request is tried against four acknowledge behaviours: all acknowledges follow, switch status stuck, SRAM acknowledge stuck, and bus-protection status stuck. The first shows the full step order. Each stuck case shows which wait gates which later step, and that the timeout fires a fixed count after the last change. Repeat requests separate the short path, taken from a known state, from the full rerun needed after an error. A second instance with both masks zero shows that the skipped waits and the untouched bus field do not depend on the acknowledge inputs.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int CTL_W  = 5;
  localparam int PDN_W  = 4;
  localparam int B_RSTN = 0;
  localparam int B_ISO  = 1;
  localparam int B_SW1  = 2;
  localparam int B_SW2  = 3;
  localparam int B_CKOF = 4;
  localparam logic [CTL_W-1:0] CTL_OFF = 5'b10010;

  typedef enum logic [4:0] {
    S_IDLE,
    S_U_SW1, S_U_SW2, S_U_WPWR, S_U_CLK, S_U_ISO, S_U_RST,
    S_U_SRAM, S_U_WSRAM, S_U_BUS, S_U_WBUS,
    S_D_BUS, S_D_WBUS, S_D_SRAM, S_D_WSRAM,
    S_D_ISO, S_D_RST, S_D_CLK, S_D_SW1, S_D_SW2, S_D_WPWR
  } seq_state_t;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= RELOAD;
    else if (load)                cnt <= RELOAD;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9: count never leaves its reload window
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RELOAD);
endmodule

// File: rtl/pwrseq_ackcheck.sv
module pwrseq_ackcheck #(
  parameter int           W    = 4,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic [W-1:0] vec,
  output logic         all_set,
  output logic         all_clr
);
  generate
    if (MASK == '0) begin : g_empty
      assign all_set = 1'b1;
      assign all_clr = 1'b1;
    end else begin : g_masked
      logic [W-1:0] sel;
      assign sel     = vec & MASK;
      assign all_set = (sel == MASK);
      assign all_clr = (sel == '0);
    end
  endgenerate
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int               BUS_W     = 4,
  parameter logic [BUS_W-1:0] BUS_MASK  = '1,
  parameter bit               SRAM_USED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_on,
  input  logic               pwr_up_ok,
  input  logic               pwr_dn_ok,
  input  logic               sram_set,
  input  logic               sram_clr,
  input  logic               bus_set,
  input  logic               bus_clr,
  input  logic               tmo,
  output logic               tmr_load,
  output logic               tmr_run,
  output logic               req_ready,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [CTL_W-1:0]   ctl,
  output logic [PDN_W-1:0]   pdn,
  output logic [BUS_W-1:0]   bus_req
);
  localparam bit BUS_USED = (BUS_MASK != '0);

  seq_state_t state;
  logic       known, dom_on, in_wait, start;

  assign in_wait   = (state == S_U_WPWR)  || (state == S_U_WSRAM) ||
                     (state == S_U_WBUS)  || (state == S_D_WBUS)  ||
                     (state == S_D_WSRAM) || (state == S_D_WPWR);
  assign tmr_load  = !in_wait;
  assign tmr_run   = in_wait;
  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      known   <= 1'b1;
      dom_on  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      ctl     <= CTL_OFF;
      pdn     <= '1;
      bus_req <= BUS_MASK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err <= 1'b0;
          if (known && dom_on == req_on) done <= 1'b1;
          else if (req_on)               state <= S_U_SW1;
          else if (BUS_USED)             state <= S_D_BUS;
          else                           state <= S_D_SRAM;
        end
        S_U_SW1:  begin ctl[B_SW1] <= 1'b1; state <= S_U_SW2;  end
        S_U_SW2:  begin ctl[B_SW2] <= 1'b1; state <= S_U_WPWR; end
        S_U_WPWR: if (pwr_up_ok) state <= S_U_CLK;
                  else if (tmo) begin err <= 1'b1; known <= 1'b0; state <= S_IDLE; end
        S_U_CLK:  begin ctl[B_CKOF] <= 1'b0; state <= S_U_ISO; end
        S_U_ISO:  begin ctl[B_ISO]  <= 1'b0; state <= S_U_RST; end
        S_U_RST:  begin ctl[B_RSTN] <= 1'b1; state <= S_U_SRAM; end
        S_U_SRAM: begin
          pdn <= '0;
          if (SRAM_USED)     state <= S_U_WSRAM;
          else if (BUS_USED) state <= S_U_BUS;
          else begin state <= S_IDLE; done <= 1'b1; known <= 1'b1; dom_on <= 1'b1; end
        end
        S_U_WSRAM: if (sram_clr) begin
                     if (BUS_USED) state <= S_U_BUS;
                     else begin state <= S_IDLE; done <= 1'b1; known <= 1'b1; dom_on <= 1'b1; end
                   end else if (tmo) begin err <= 1'b1; known <= 1'b0; state <= S_IDLE; end
        S_U_BUS:  begin bus_req <= '0; state <= S_U_WBUS; end
        S_U_WBUS: if (bus_clr) begin
                    state <= S_IDLE; done <= 1'b1; known <= 1'b1; dom_on <= 1'b1;
                  end else if (tmo) begin err <= 1'b1; known <= 1'b0; state <= S_IDLE; end
        S_D_BUS:  begin bus_req <= BUS_MASK; state <= S_D_WBUS; end
        S_D_WBUS: if (bus_set) state <= S_D_SRAM;
                  else if (tmo) begin err <= 1'b1; known <= 1'b0; state <= S_IDLE; end
        S_D_SRAM: begin pdn <= '1; state <= SRAM_USED ? S_D_WSRAM : S_D_ISO; end
        S_D_WSRAM: if (sram_set) state <= S_D_ISO;
                   else if (tmo) begin err <= 1'b1; known <= 1'b0; state <= S_IDLE; end
        S_D_ISO:  begin ctl[B_ISO]  <= 1'b1; state <= S_D_RST; end
        S_D_RST:  begin ctl[B_RSTN] <= 1'b0; state <= S_D_CLK; end
        S_D_CLK:  begin ctl[B_CKOF] <= 1'b1; state <= S_D_SW1; end
        S_D_SW1:  begin ctl[B_SW1]  <= 1'b0; state <= S_D_SW2; end
        S_D_SW2:  begin ctl[B_SW2]  <= 1'b0; state <= S_D_WPWR; end
        S_D_WPWR: if (pwr_dn_ok) begin
                    state <= S_IDLE; done <= 1'b1; known <= 1'b1; dom_on <= 1'b0;
                  end else if (tmo) begin err <= 1'b1; known <= 1'b0; state <= S_IDLE; end
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R8: one output group moves per cycle
  p_one_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctl ^ $past(ctl), pdn != $past(pdn), bus_req != $past(bus_req)}) <= 1);

  // R2: an accepted request leaves the sequencer busy or finishes at once
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy || done));
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pwrseq_pkg::*;
#(
  parameter int                    SRAM_ACK_W    = 6,
  parameter logic [SRAM_ACK_W-1:0] SRAM_ACK_MASK = 6'b001111,
  parameter int                    BUS_W         = 4,
  parameter logic [BUS_W-1:0]      BUS_MASK      = 4'b1111,
  parameter int                    TIMEOUT       = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_on,
  output logic                  req_ready,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [4:0]            pwr_ctl,
  output logic [3:0]            sram_pdn,
  output logic [BUS_W-1:0]      bus_prot_req,
  input  logic                  pwr_ack_a,
  input  logic                  pwr_ack_b,
  input  logic [SRAM_ACK_W-1:0] sram_ack,
  input  logic [BUS_W-1:0]      bus_prot_sta
);
  localparam bit SRAM_USED = (SRAM_ACK_MASK != '0);

  logic sram_set, sram_clr, bus_set, bus_clr;
  logic tmr_load, tmr_run, tmo;

  pwrseq_ackcheck #(.W(SRAM_ACK_W), .MASK(SRAM_ACK_MASK)) u_sram_chk (
    .vec(sram_ack), .all_set(sram_set), .all_clr(sram_clr));

  pwrseq_ackcheck #(.W(BUS_W), .MASK(BUS_MASK)) u_bus_chk (
    .vec(bus_prot_sta), .all_set(bus_set), .all_clr(bus_clr));

  pwrseq_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .expired(tmo));

  pwrseq_fsm #(.BUS_W(BUS_W), .BUS_MASK(BUS_MASK), .SRAM_USED(SRAM_USED)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
    .pwr_up_ok(pwr_ack_a && pwr_ack_b), .pwr_dn_ok(!pwr_ack_a && !pwr_ack_b),
    .sram_set(sram_set), .sram_clr(sram_clr), .bus_set(bus_set), .bus_clr(bus_clr),
    .tmo(tmo), .tmr_load(tmr_load), .tmr_run(tmr_run), .req_ready(req_ready),
    .busy(busy), .done(done), .err(err), .ctl(pwr_ctl), .pdn(sram_pdn),
    .bus_req(bus_prot_req));

  // R3: reset is released only with switches on, clock and isolation off
  p_rst_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ctl[B_RSTN]) |->
      (pwr_ctl[B_SW1] && pwr_ctl[B_SW2] && !pwr_ctl[B_ISO] && !pwr_ctl[B_CKOF]));

  // R4: isolation goes on only after SRAM is powered down
  p_iso_after_sram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ctl[B_ISO]) |-> (sram_pdn == 4'hF));

  // R5: clock enabled only after both switch acks were seen high
  p_clk_needs_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[B_CKOF]) |-> $past(pwr_ack_a && pwr_ack_b, 2));

  // R7: bus protection drops only with the domain fully alive
  p_bus_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|bus_prot_req) |-> (sram_pdn == 4'h0 && pwr_ctl == 5'b01101));

  // R11: done never overlaps a running sequence
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));
endmodule

// File: tb/tb_pwr_domain_seq.sv
module tb_pwr_domain_seq;
  localparam int               TMO   = 8;
  localparam logic [5:0]       SMASK = 6'b101101;
  localparam logic [3:0]       BMASK = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_on = 1'b0;
  logic req_ready, busy, done, err;
  logic [4:0] pwr_ctl;
  logic [3:0] sram_pdn;
  logic [3:0] bus_req;
  logic a1, a2, ack_a, ack_b;
  logic [5:0] sram_ack;
  logic [3:0] bus_sta, bus_d;
  logic [3:0] pdn_d;
  int stuck = 0;

  pwr_domain_seq #(.SRAM_ACK_W(6), .SRAM_ACK_MASK(SMASK), .BUS_W(4),
                   .BUS_MASK(BMASK), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
    .req_ready(req_ready), .busy(busy), .done(done), .err(err),
    .pwr_ctl(pwr_ctl), .sram_pdn(sram_pdn), .bus_prot_req(bus_req),
    .pwr_ack_a(ack_a), .pwr_ack_b(ack_b), .sram_ack(sram_ack),
    .bus_prot_sta(bus_sta));

  // acknowledge model: two-cycle follow, frozen when stuck
  always_ff @(posedge clk) begin
    a1 <= pwr_ctl[2]; a2 <= pwr_ctl[3]; pdn_d <= sram_pdn; bus_d <= bus_req;
    if (stuck != 1) begin ack_a <= a1; ack_b <= a2; end
    if (stuck != 2) sram_ack <= {pdn_d[1:0], pdn_d};
    if (stuck != 3) bus_sta <= bus_d;
  end

  // second instance with both masks empty
  logic nm_valid = 1'b0, nm_on = 1'b0;
  logic nm_ready, nm_busy, nm_done, nm_err;
  logic [4:0] nm_ctl;
  logic [3:0] nm_pdn, nm_bus;
  logic nm_a, nm_b;
  always_ff @(posedge clk) begin nm_a <= nm_ctl[2]; nm_b <= nm_ctl[3]; end

  pwr_domain_seq #(.SRAM_ACK_W(6), .SRAM_ACK_MASK(6'b0), .BUS_W(4),
                   .BUS_MASK(4'b0), .TIMEOUT(TMO)) dut_nm (
    .clk(clk), .rst_n(rst_n), .req_valid(nm_valid), .req_on(nm_on),
    .req_ready(nm_ready), .busy(nm_busy), .done(nm_done), .err(nm_err),
    .pwr_ctl(nm_ctl), .sram_pdn(nm_pdn), .bus_prot_req(nm_bus),
    .pwr_ack_a(nm_a), .pwr_ack_b(nm_b), .sram_ack(6'h3F), .bus_prot_sta(4'hF));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor: event codes 0..4 = control bit, 5 = sram field, 6 = bus field
  int ev[0:511];
  int ev_tot = 0, cyc = 0, last_ev_cyc = 0, err_cyc = 0;
  int done_cnt = 0, multi = 0, long_done = 0;
  logic [4:0] p_ctl; logic [3:0] p_pdn, p_bus; logic p_err, p_done;
  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      n = 0;
      cyc++;
      for (int b = 0; b < 5; b++)
        if (pwr_ctl[b] != p_ctl[b]) begin ev[ev_tot % 512] = b; ev_tot++; n++; end
      if (sram_pdn != p_pdn) begin ev[ev_tot % 512] = 5; ev_tot++; n++; end
      if (bus_req != p_bus)  begin ev[ev_tot % 512] = 6; ev_tot++; n++; end
      if (n > 0) last_ev_cyc = cyc;
      if (n > 1) multi++;
      if (err && !p_err) err_cyc = cyc;
      if (done) done_cnt++;
      if (done && p_done) long_done++;
    end
    p_ctl = pwr_ctl; p_pdn = sram_pdn; p_bus = bus_req; p_err = err; p_done = done;
  end

  // expected-state model built from the requirements
  logic [4:0] m_ctl; logic [3:0] m_pdn, m_bus; bit m_known, m_on;
  int exp_ev[0:15]; int exp_n; bit exp_err;

  task automatic put_ctl(input int b, input logic v);
    if (m_ctl[b] != v) begin m_ctl[b] = v; exp_ev[exp_n] = b; exp_n++; end
  endtask
  task automatic put_pdn(input logic [3:0] v);
    if (m_pdn != v) begin m_pdn = v; exp_ev[exp_n] = 5; exp_n++; end
  endtask
  task automatic put_bus(input logic [3:0] v);
    if (m_bus != v) begin m_bus = v; exp_ev[exp_n] = 6; exp_n++; end
  endtask

  task automatic model(input bit on, input int stk);
    exp_n = 0; exp_err = 0;
    if (m_known && m_on == on) return;
    if (on) begin
      put_ctl(2, 1); put_ctl(3, 1);
      if (stk == 1) begin exp_err = 1; m_known = 0; return; end
      put_ctl(4, 0); put_ctl(1, 0); put_ctl(0, 1); put_pdn(4'h0);
      if (stk == 2) begin exp_err = 1; m_known = 0; return; end
      put_bus(4'h0);
      if (stk == 3) begin exp_err = 1; m_known = 0; return; end
    end else begin
      put_bus(BMASK);
      if (stk == 3) begin exp_err = 1; m_known = 0; return; end
      put_pdn(4'hF);
      if (stk == 2) begin exp_err = 1; m_known = 0; return; end
      put_ctl(1, 1); put_ctl(0, 0); put_ctl(4, 1); put_ctl(2, 0); put_ctl(3, 0);
      if (stk == 1) begin exp_err = 1; m_known = 0; return; end
    end
    m_known = 1; m_on = on;
  endtask

  // vector table: {req_on, stuck[1:0]}; stuck 1 = switch status, 2 = SRAM ack, 3 = bus status
  localparam int NV = 15;
  localparam logic [2:0] VEC [NV] = '{
    3'b1_00, 3'b1_00, 3'b0_00, 3'b0_00, 3'b1_01, 3'b0_00, 3'b1_10, 3'b0_00,
    3'b1_00, 3'b0_01, 3'b1_11, 3'b0_00, 3'b0_00, 3'b1_00, 3'b1_00 };

  task automatic run_row(input int idx, input bit on, input int stk);
    int st, d0, guard;
    bit saw_ready_low;
    string tag;
    model(on, stk);
    stuck = stk;
    @(negedge clk);
    st = ev_tot; d0 = done_cnt;
    chk(req_ready == 1'b1, "R2 ready while idle", int'(req_ready), 1);
    req_valid = 1'b1; req_on = on;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0; saw_ready_low = 1;
    while (busy && guard < 200) begin
      if (req_ready) saw_ready_low = 0;
      @(negedge clk); guard++;
    end
    repeat (2) @(negedge clk);
    chk(saw_ready_low, "R2 ready low while busy", 0, 1);
    tag = on ? "R3 up order" : "R4 down order";
    if (exp_n == 0) tag = "R10 same-state no change";
    chk(ev_tot - st == exp_n, tag, ev_tot - st, exp_n);
    for (int k = 0; k < exp_n && k < ev_tot - st; k++)
      chk(ev[(st + k) % 512] == exp_ev[k], tag, ev[(st + k) % 512], exp_ev[k]);
    chk(err == exp_err, stk == 1 ? "R5 switch wait" : stk == 2 ? "R6 sram wait" :
        stk == 3 ? "R7 bus wait" : "R9 no error", int'(err), int'(exp_err));
    chk(done_cnt - d0 == (exp_err ? 0 : 1), "R11 done pulse", done_cnt - d0, exp_err ? 0 : 1);
    if (exp_err)
      chk(err_cyc - last_ev_cyc == TMO, "R9 timeout length", err_cyc - last_ev_cyc, TMO);
    stuck = 0;
    repeat (5) @(negedge clk);
    if (exp_err)
      chk(ev_tot - st == exp_n, "R9 outputs held after error", ev_tot - st, exp_n);
    if (idx < 0) $display("row %0d", idx);
  endtask

  bit finished = 0;
  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    m_ctl = 5'b10010; m_pdn = 4'hF; m_bus = BMASK; m_known = 1; m_on = 0;
    repeat (4) @(negedge clk);
    chk(pwr_ctl == 5'b10010, "R1 reset ctl", int'(pwr_ctl), 18);
    chk(sram_pdn == 4'hF, "R1 reset sram", int'(sram_pdn), 15);
    chk(bus_req == BMASK, "R1 reset bus", int'(bus_req), int'(BMASK));
    chk(!busy && !done && !err && req_ready, "R1 reset status",
        int'({busy, done, err, req_ready}), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_row(i, VEC[i][2], int'(VEC[i][1:0]));

    chk(multi == 0, "R8 one change per cycle", multi, 0);
    chk(long_done == 0, "R11 done one cycle", long_done, 0);

    // R6 R7: empty masks skip the waits, bus field untouched
    @(negedge clk); nm_valid = 1'b1; nm_on = 1'b1;
    @(negedge clk); nm_valid = 1'b0;
    for (int g = 0; g < 60 && nm_busy; g++) @(negedge clk);
    @(negedge clk);
    chk(!nm_err && nm_ctl == 5'b01101 && nm_pdn == 4'h0, "R6 empty sram mask up",
        int'(nm_ctl), 13);
    chk(nm_bus == 4'h0, "R7 empty bus mask up", int'(nm_bus), 0);
    nm_valid = 1'b1; nm_on = 1'b0;
    @(negedge clk); nm_valid = 1'b0;
    for (int g = 0; g < 60 && nm_busy; g++) @(negedge clk);
    @(negedge clk);
    chk(!nm_err && nm_ctl == 5'b10010 && nm_pdn == 4'hF, "R6 empty sram mask down",
        int'(nm_ctl), 18);
    chk(nm_bus == 4'h0, "R7 empty bus mask down", int'(nm_bus), 0);

    wrap_up();
  end
endmodule